// File: doc/BRIEF.md
# Configuration Access Request Sequencer

This engine turns a single host request for PCIe configuration space into one programmed-I/O transaction on a register-style core port. A request names a bus, device, function, register offset, access size, direction and, for writes, the data. The engine first screens the request. It rejects misaligned accesses, and it refuses to reach a nonzero device on the root bus, because only device 0 can sit behind the root port. It then derives the transaction type, the address word, the byte strobe and the lane-aligned write data. Before raising start it clears the core's start and done flags. It then polls for completion a bounded number of times and converts the core's completion status into read data or a result code.

The host side is a valid/ready request channel. `req_ready` is high only while the engine is idle, so at most one request is in flight. A request held valid while `req_ready` is low simply waits. There is no back-pressure on the response: it is a one-cycle `rsp_valid` pulse that carries `rsp_code` and `rsp_data`, and the host must take it in that cycle. The core side is plain: a clear pulse, a go pulse, stable transaction fields, and the inputs busy (start read-back), done, status and read data.

Top module: `cfg_access_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. After acceptance `req_ready` stays 0 until the response pulse has been issued.
- R2: Each accepted request yields exactly one `rsp_valid` pulse of one cycle. Result codes: 0 = ok, 1 = timeout, 2 = completion error, 3 = dropped.
- R3: Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. The request is dropped (code 3, data 0, no launch) in three cases: size code 3, a 16-bit access with offset bit 0 set, or a 32-bit access with offset bits 1:0 nonzero. This check takes priority over R4.
- R4: A request whose bus equals `root_bus` and whose device is nonzero is not launched and returns code 0. A read returns all-ones sized to the access (0xFF, 0xFFFF or 0xFFFFFFFF). A write returns data 0.
- R5: The transaction type is 0x8 for a read and 0xA for a write when the bus equals `root_bus`. For any other bus it is 0x9 for a read and 0xB for a write.
- R6: The low address word holds bus at bits 27:20, device at 19:15, function at 14:12 and offset bits 11:2 in place; bits 31:28 and 1:0 are zero. The high address word is zero.
- R7: The write strobe is 4'b0001, 4'b0011 or 4'b1111 for sizes 8, 16 and 32, shifted left by offset[1:0]. The write data is the host data shifted left by 8*offset[1:0].
- R8: A launch is a one-cycle `core_clr` pulse followed in the very next cycle by a one-cycle `core_go` pulse.
- R9: After launch the engine waits WAIT_CYC cycles, then checks the core. The access has completed when `core_busy` is 0 and `core_done` is 1. After MAX_TRY failed checks, each preceded by a wait, the response is code 1 with data 0.
- R10: The completion status is `core_stat[9:7]`. Status 0 with `core_stat[11]` clear gives code 0. For a read, the data is `core_rdata` shifted right by 8*offset[1:0], masked to the access size and zero-extended. For a write, the data is 0.
- R11: Status 0 with `core_stat[11]` set gives code 2. Status 4 gives code 2. Any value other than 0, 1, 2 and 4 gives code 2. Every error response carries data 0.
- R12: For a read, status 1 returns 0xFFFFFFFF and status 2 returns 0xFFFF0001, both with code 0 and both unsized. For a write, status 1 or 2 gives code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_bus | input | 8 | Bus number of the root port |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request can be accepted |
| req_bus | input | 8 | Target bus |
| req_dev | input | 5 | Target device |
| req_fn | input | 3 | Target function |
| req_off | input | 12 | Register byte offset |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | Result code |
| rsp_data | output | 32 | Read result |
| core_clr | output | 1 | Clear start and done flags |
| core_go | output | 1 | Set start flag |
| core_type | output | 4 | Transaction type |
| core_addr_lo | output | 32 | Low address word |
| core_addr_hi | output | 32 | High address word |
| core_wdata | output | 32 | Lane-aligned write data |
| core_strb | output | 4 | Write byte strobe |
| core_busy | input | 1 | Start flag read-back |
| core_done | input | 1 | Completion flag |
| core_stat | input | 12 | Completion status word |
| core_rdata | input | 32 | Read data from core |

## Verification
The scoreboard compares every launch field and every response against values the bench computes itself. It would catch a design that launches a rejected request, picks the wrong type for a non-root bus, or places a byte lane wrongly at offset 3. A request that is both misaligned and aimed at an invalid device must come back dropped. A design with the checks in the wrong order would answer it with all-ones. The bench feeds each sentinel status once as a read and once as a write. An inverted direction test would return a sentinel on a write. Status OK with the error bit set must fail, so a decoder that looks only at bits 9:7 is exposed. A core that never finishes must produce a timeout. A retry counter that never wraps would hang the bench, and one that is off by one would report completion wrongly for a slow core.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int OFF_W  = 12;
  localparam int DATA_W = 32;
  localparam int STAT_W = 12;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  localparam logic [1:0] RC_OK      = 2'd0;
  localparam logic [1:0] RC_TIMEOUT = 2'd1;
  localparam logic [1:0] RC_CPLERR  = 2'd2;
  localparam logic [1:0] RC_DROP    = 2'd3;

  localparam logic [2:0] CS_OK  = 3'd0;
  localparam logic [2:0] CS_UR  = 3'd1;
  localparam logic [2:0] CS_CRS = 3'd2;

  localparam logic [DATA_W-1:0] UR_WORD  = 32'hFFFF_FFFF;
  localparam logic [DATA_W-1:0] CRS_WORD = 32'hFFFF_0001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_CLR, ST_GO, ST_WAIT, ST_POLL
  } seq_state_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    return 32'h0000_00FF;
      SZ_H:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgseq_decode.sv
module cfgseq_decode
  import cfgseq_pkg::*;
(
  input  logic [BUS_W-1:0]  root_bus,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  output logic [3:0]        typ,
  output logic [DATA_W-1:0] addr_lo,
  output logic [3:0]        strb,
  output logic [DATA_W-1:0] lane_wdata,
  output logic              misaligned,
  output logic              bad_target,
  output logic [DATA_W-1:0] ones_sized
);
  logic on_root;
  assign on_root    = (bus == root_bus);
  assign bad_target = on_root && (dev != '0);

  always_comb begin
    case (size)
      SZ_B:    misaligned = 1'b0;
      SZ_H:    misaligned = off[0];
      SZ_W:    misaligned = (off[1:0] != 2'b00);
      default: misaligned = 1'b1;
    endcase
  end

  // type: bit1 = write, bit0 = beyond root bus
  assign typ = {2'b10, write, ~on_root};

  assign addr_lo = {4'b0000, bus, dev, fn, off[OFF_W-1:2], 2'b00};

  always_comb begin
    case (size)
      SZ_B:    strb = 4'b0001 << off[1:0];
      SZ_H:    strb = 4'b0011 << off[1:0];
      default: strb = 4'b1111;
    endcase
  end

  assign lane_wdata = wdata << {off[1:0], 3'b000};
  assign ones_sized = size_mask(size);
endmodule

// File: rtl/cfgseq_resolve.sv
module cfgseq_resolve
  import cfgseq_pkg::*;
(
  input  logic [STAT_W-1:0] stat,
  input  logic [DATA_W-1:0] rdata,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [1:0]        lane,
  output logic [1:0]        code,
  output logic [DATA_W-1:0] data
);
  logic [2:0]        cs;
  logic              err_flag;
  logic [DATA_W-1:0] picked;

  assign cs       = stat[9:7];
  assign err_flag = stat[11];
  assign picked   = (rdata >> {lane, 3'b000}) & size_mask(size);

  always_comb begin
    code = RC_CPLERR;
    data = '0;
    case (cs)
      CS_OK: if (!err_flag) begin
        code = RC_OK;
        data = write ? '0 : picked;
      end
      CS_UR: if (!write) begin
        code = RC_OK;
        data = UR_WORD;
      end
      CS_CRS: if (!write) begin
        code = RC_OK;
        data = CRS_WORD;
      end
      default: begin
        code = RC_CPLERR;
        data = '0;
      end
    endcase
  end
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfgseq_pkg::*;
#(
  parameter int WAIT_CYC = 16,
  parameter int MAX_TRY  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  root_bus,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_fn,
  input  logic [11:0] req_off,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [1:0]  rsp_code,
  output logic [31:0] rsp_data,
  output logic        core_clr,
  output logic        core_go,
  output logic [3:0]  core_type,
  output logic [31:0] core_addr_lo,
  output logic [31:0] core_addr_hi,
  output logic [31:0] core_wdata,
  output logic [3:0]  core_strb,
  input  logic        core_busy,
  input  logic        core_done,
  input  logic [11:0] core_stat,
  input  logic [31:0] core_rdata
);
  localparam int WC_W = $clog2(WAIT_CYC + 1);
  localparam int TR_W = $clog2(MAX_TRY + 1);

  seq_state_t        state;
  logic [BUS_W-1:0]  q_bus;
  logic [DEV_W-1:0]  q_dev;
  logic [FN_W-1:0]   q_fn;
  logic [OFF_W-1:0]  q_off;
  logic [1:0]        q_size;
  logic              q_write;
  logic [DATA_W-1:0] q_wdata;
  logic [WC_W-1:0]   wcnt;
  logic [TR_W-1:0]   tries;

  logic              dec_mis, dec_bad;
  logic [DATA_W-1:0] dec_ones;
  logic [1:0]        res_code;
  logic [DATA_W-1:0] res_data;

  cfgseq_decode u_dec (
    .root_bus   (root_bus),
    .bus        (q_bus),
    .dev        (q_dev),
    .fn         (q_fn),
    .off        (q_off),
    .size       (q_size),
    .write      (q_write),
    .wdata      (q_wdata),
    .typ        (core_type),
    .addr_lo    (core_addr_lo),
    .strb       (core_strb),
    .lane_wdata (core_wdata),
    .misaligned (dec_mis),
    .bad_target (dec_bad),
    .ones_sized (dec_ones)
  );

  cfgseq_resolve u_res (
    .stat  (core_stat),
    .rdata (core_rdata),
    .write (q_write),
    .size  (q_size),
    .lane  (q_off[1:0]),
    .code  (res_code),
    .data  (res_data)
  );

  assign core_addr_hi = '0;
  assign req_ready    = (state == ST_IDLE);
  assign core_clr     = (state == ST_CLR);
  assign core_go      = (state == ST_GO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      q_bus     <= '0;
      q_dev     <= '0;
      q_fn      <= '0;
      q_off     <= '0;
      q_size    <= '0;
      q_write   <= 1'b0;
      q_wdata   <= '0;
      wcnt      <= '0;
      tries     <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= RC_OK;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          q_bus   <= req_bus;
          q_dev   <= req_dev;
          q_fn    <= req_fn;
          q_off   <= req_off;
          q_size  <= req_size;
          q_write <= req_write;
          q_wdata <= req_wdata;
          state   <= ST_EVAL;
        end
        ST_EVAL: begin
          if (dec_mis) begin
            rsp_valid <= 1'b1;
            rsp_code  <= RC_DROP;
            rsp_data  <= '0;
            state     <= ST_IDLE;
          end else if (dec_bad) begin
            rsp_valid <= 1'b1;
            rsp_code  <= RC_OK;
            rsp_data  <= q_write ? '0 : dec_ones;
            state     <= ST_IDLE;
          end else begin
            state <= ST_CLR;
          end
        end
        ST_CLR: state <= ST_GO;
        ST_GO: begin
          wcnt  <= '0;
          tries <= '0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt == WC_W'(WAIT_CYC - 1)) state <= ST_POLL;
          else wcnt <= wcnt + 1'b1;
        end
        ST_POLL: begin
          if (!core_busy && core_done) begin
            rsp_valid <= 1'b1;
            rsp_code  <= res_code;
            rsp_data  <= res_data;
            state     <= ST_IDLE;
          end else if (tries == TR_W'(MAX_TRY - 1)) begin
            rsp_valid <= 1'b1;
            rsp_code  <= RC_TIMEOUT;
            rsp_data  <= '0;
            state     <= ST_IDLE;
          end else begin
            tries <= tries + 1'b1;
            wcnt  <= '0;
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: one request in flight
  p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2: response is a single-cycle strobe
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R3/R4: rejected requests never reach the core
  p_no_launch_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_go |-> (!dec_mis && !dec_bad));
  // R8: go directly follows clear
  p_clr_then_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_go |-> $past(core_clr));
  // R9: poll count stays within budget
  p_poll_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL) |-> (tries < TR_W'(MAX_TRY)));
  // R9: timeout only on the final allowed check
  p_timeout_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_TIMEOUT) |-> ($past(tries) == TR_W'(MAX_TRY - 1)));
endmodule

// File: tb/cfg_access_seq_tb_top.sv
module cfg_access_seq_tb_top;
  localparam int WAIT_CYC = 3;
  localparam int MAX_TRY  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  root_bus = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_data;
  logic        core_clr, core_go;
  logic [3:0]  core_type;
  logic [31:0] core_addr_lo, core_addr_hi, core_wdata;
  logic [3:0]  core_strb;
  logic        core_busy = 1'b0;
  logic        core_done = 1'b0;
  logic [11:0] core_stat = '0;
  logic [31:0] core_rdata = '0;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int lcnt = 0;
  logic prev_clr = 1'b0;

  typedef struct {
    logic [3:0]  typ;
    logic [31:0] addr;
    logic [3:0]  strb;
    logic [31:0] wd;
    string       tag;
  } launch_t;
  typedef struct {
    logic [1:0]  code;
    logic [31:0] data;
    string       tag;
  } resp_t;
  launch_t lq[$];
  resp_t   rq[$];

  always #5 clk = ~clk;

  cfg_access_seq #(.WAIT_CYC(WAIT_CYC), .MAX_TRY(MAX_TRY)) dut_i (
    .clk(clk), .rst_n(rst_n), .root_bus(root_bus),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .core_clr(core_clr), .core_go(core_go), .core_type(core_type),
    .core_addr_lo(core_addr_lo), .core_addr_hi(core_addr_hi),
    .core_wdata(core_wdata), .core_strb(core_strb),
    .core_busy(core_busy), .core_done(core_done),
    .core_stat(core_stat), .core_rdata(core_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // core model
  always @(posedge clk) begin
    if (core_clr) begin
      core_busy <= 1'b0;
      core_done <= 1'b0;
    end else if (core_go) begin
      core_busy <= 1'b1;
      lcnt      <= lat;
    end else if (core_busy) begin
      if (lcnt == 0) begin
        core_busy <= 1'b0;
        core_done <= 1'b1;
      end else lcnt <= lcnt - 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (core_go) begin
        chk(prev_clr, "R8 clear before go", {31'b0, prev_clr}, 32'd1);
        if (lq.size() == 0) chk(1'b0, "R3/R4 unexpected launch", core_addr_lo, 32'd0);
        else begin
          launch_t e;
          e = lq.pop_front();
          chk(core_type == e.typ, {"R5 type ", e.tag}, {28'b0, core_type}, {28'b0, e.typ});
          chk(core_addr_lo == e.addr && core_addr_hi == 32'd0, {"R6 addr ", e.tag}, core_addr_lo, e.addr);
          if (e.typ[1]) begin
            chk(core_strb == e.strb, {"R7 strb ", e.tag}, {28'b0, core_strb}, {28'b0, e.strb});
            chk(core_wdata == e.wd, {"R7 wdata ", e.tag}, core_wdata, e.wd);
          end
        end
      end
      if (rsp_valid) begin
        if (rq.size() == 0) chk(1'b0, "R2 unexpected response", rsp_data, 32'd0);
        else begin
          resp_t r;
          r = rq.pop_front();
          chk(rsp_code == r.code, {"code ", r.tag}, {30'b0, rsp_code}, {30'b0, r.code});
          chk(rsp_data == r.data, {"data ", r.tag}, rsp_data, r.data);
        end
      end
      prev_clr = core_clr;
    end
  end

  // driver: pushes expectations, then issues one request
  task automatic send(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                      input logic [11:0] o, input logic [1:0] sz, input logic wr,
                      input logic [31:0] wd, input logic [11:0] st, input logic [31:0] rd,
                      input int l, input bit launch, input logic [1:0] ecode,
                      input logic [31:0] edata, input string tag);
    launch_t li;
    resp_t   ri;
    logic [3:0] s;
    if (launch) begin
      li.typ  = (b == root_bus) ? (wr ? 4'hA : 4'h8) : (wr ? 4'hB : 4'h9);
      li.addr = (32'(b) << 20) | (32'(d) << 15) | (32'(f) << 12) | (32'(o) & 32'hFFC);
      s = (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
      li.strb = s << o[1:0];
      li.wd   = wd << (8 * o[1:0]);
      li.tag  = tag;
      lq.push_back(li);
    end
    ri.code = ecode;
    ri.data = edata;
    ri.tag  = tag;
    rq.push_back(ri);
    core_stat  = st;
    core_rdata = rd;
    lat        = l;
    @(negedge clk);
    req_bus = b; req_dev = d; req_fn = f; req_off = o;
    req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    chk(req_ready == 1'b1, {"R1 ready idle ", tag}, {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {"R1 busy after accept ", tag}, {31'b0, req_ready}, 32'd0);
    while (rq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(lq.size() == 0, {"R8 launch seen ", tag}, 32'(lq.size()), 32'd0);
    lq.delete();
  endtask

  localparam logic [11:0] ST_OK  = 12'h000;
  localparam logic [11:0] ST_UR  = 12'd1 << 7;
  localparam logic [11:0] ST_CRS = 12'd2 << 7;
  localparam logic [11:0] ST_CA  = 12'd4 << 7;
  localparam logic [11:0] ST_UNK = 12'd3 << 7;
  localparam logic [11:0] ST_ERR = 12'h800;

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && core_go == 1'b0 && core_clr == 1'b0, "R2 reset outputs idle", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'd1);

    // R10 reads, R5 type 0/1, R6 address
    send(8'd0, 5'd0, 3'd2, 12'h010, 2'd2, 1'b0, 0, ST_OK, 32'hDEADBEEF, 2, 1, 2'd0, 32'hDEADBEEF, "R10 rd32 root");
    send(8'd5, 5'd3, 3'd1, 12'h02E, 2'd1, 1'b0, 0, ST_OK, 32'hCAFE1234, 0, 1, 2'd0, 32'h0000CAFE, "R10 rd16 type1");
    send(8'd2, 5'd31, 3'd7, 12'hFFF, 2'd0, 1'b0, 0, ST_OK, 32'hA1B2C3D4, 5, 1, 2'd0, 32'h000000A1, "R10 rd8 lane3");
    // R7 writes
    send(8'd0, 5'd0, 3'd0, 12'h041, 2'd0, 1'b1, 32'h000000A5, ST_OK, 0, 1, 1, 2'd0, 0, "R7 wr8 root");
    send(8'd9, 5'd4, 3'd3, 12'h102, 2'd1, 1'b1, 32'h00001234, ST_OK, 0, 3, 1, 2'd0, 0, "R7 wr16 type1");
    send(8'd1, 5'd1, 3'd0, 12'h3FC, 2'd2, 1'b1, 32'h89ABCDEF, ST_OK, 0, 20, 1, 2'd0, 0, "R7 wr32 slow");
    // R4 invalid target
    send(8'd0, 5'd1, 3'd0, 12'h002, 2'd1, 1'b0, 0, ST_OK, 0, 0, 0, 2'd0, 32'h0000FFFF, "R4 rd16 ones");
    send(8'd0, 5'd7, 3'd0, 12'h003, 2'd0, 1'b0, 0, ST_OK, 0, 0, 0, 2'd0, 32'h000000FF, "R4 rd8 ones");
    send(8'd0, 5'd2, 3'd0, 12'h000, 2'd2, 1'b1, 32'h1, ST_OK, 0, 0, 0, 2'd0, 0, "R4 wr dropped ok");
    // R3 misaligned
    send(8'd3, 5'd0, 3'd0, 12'h001, 2'd1, 1'b0, 0, ST_OK, 0, 0, 0, 2'd3, 0, "R3 rd16 odd");
    send(8'd3, 5'd0, 3'd0, 12'h002, 2'd2, 1'b1, 32'h5, ST_OK, 0, 0, 0, 2'd3, 0, "R3 wr32 off2");
    send(8'd3, 5'd0, 3'd0, 12'h000, 2'd3, 1'b0, 0, ST_OK, 0, 0, 0, 2'd3, 0, "R3 size3");
    send(8'd0, 5'd4, 3'd0, 12'h001, 2'd2, 1'b0, 0, ST_OK, 0, 0, 0, 2'd3, 0, "R3 before R4");
    // R12 sentinels and R11 errors
    send(8'd6, 5'd0, 3'd0, 12'h000, 2'd0, 1'b0, 0, ST_UR, 32'h12, 1, 1, 2'd0, 32'hFFFFFFFF, "R12 rd UR");
    send(8'd6, 5'd0, 3'd0, 12'h001, 2'd0, 1'b0, 0, ST_CRS, 32'h12, 1, 1, 2'd0, 32'hFFFF0001, "R12 rd CRS");
    send(8'd6, 5'd0, 3'd0, 12'h000, 2'd2, 1'b1, 32'h7, ST_UR, 0, 1, 1, 2'd2, 0, "R12 wr UR err");
    send(8'd6, 5'd0, 3'd0, 12'h000, 2'd2, 1'b1, 32'h7, ST_CRS, 0, 1, 1, 2'd2, 0, "R12 wr CRS err");
    send(8'd6, 5'd0, 3'd0, 12'h000, 2'd2, 1'b0, 0, ST_CA, 32'h55, 1, 1, 2'd2, 0, "R11 rd CA");
    send(8'd6, 5'd0, 3'd0, 12'h000, 2'd2, 1'b0, 0, ST_UNK, 32'h55, 1, 1, 2'd2, 0, "R11 rd unknown");
    send(8'd6, 5'd0, 3'd0, 12'h000, 2'd2, 1'b0, 0, ST_OK | ST_ERR, 32'h55, 1, 1, 2'd2, 0, "R11 ok with err bit");
    // R9 timeout, then recovery
    send(8'd4, 5'd0, 3'd0, 12'h020, 2'd2, 1'b0, 0, ST_OK, 32'h99, 100000, 1, 2'd1, 0, "R9 timeout");
    send(8'd4, 5'd0, 3'd0, 12'h020, 2'd2, 1'b0, 0, ST_OK, 32'h77, 0, 1, 2'd0, 32'h77, "R9 after timeout");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule